// File: doc/BRIEF.md
# Sector Hamming ECC Syndrome Corrector

This block checks a NAND page after it has been read into a sector buffer. Each 512-byte sector carries a 24-bit Hamming code. The block receives the code that was stored in flash and the code that was recomputed on read, for every sector of the page. It works through the sectors in order. For each sector it XORs the two codes into a 24-bit syndrome, taking the syndrome bits from a scrambled byte layout. It then counts the ones in the syndrome and sorts the sector into one of three outcomes: clean, correctable single-bit data error, or uncorrectable.

For a correctable sector, the block reads the faulty byte from the sector buffer and writes it back with one bit inverted. The buffer is a simple byte-wide port with a one-cycle read latency. A page is one sector, or a full page of four sectors. An uncorrectable sector ends the page at once with an error. Otherwise the page ends with the number of sectors that were repaired. The position of the most recent repair stays visible on the outputs.

Top module: `secc_corrector`

## Requirements
- R1: Byte k of the sector-s code is bits [24s+8k+7 : 24s+8k] of `stored_ecc` and `calc_ecc`. The syndrome is built from x = stored XOR computed as follows: syn[5:0] = byte2[7:2], syn[13:6] = byte0, syn[21:14] = byte1, syn[23:22] = byte2[1:0]. A sector whose two codes are equal is skipped as clean.
- R2: A clean sector causes no buffer access and leaves the error flag low.
- R3: A syndrome with exactly 1 or exactly 11 set bits makes the sector uncorrectable.
- R4: A syndrome with exactly 12 set bits is a single-bit data error. The byte offset is {syn23,syn21,syn19,syn17,syn15,syn13,syn11,syn9,syn7} and the bit index is {syn5,syn3,syn1}, each listed from most significant to least. That byte of the sector's buffer window has that bit inverted.
- R5: Any other nonzero count is uncorrectable, with one exception. If the stored code is 0xFFFFFF and the computed code is 0x000000 (an erased page), the sector counts as clean.
- R6: With `page_mode`=0 only sector 0 is processed. With `page_mode`=1 sectors 0 to 3 are processed in order. Sector s uses buffer addresses s*512 + offset.
- R7: `corr_cnt` reports the number of corrected sectors. An uncorrectable sector sets `err` and ends the page: later sectors are neither examined nor written, and the sectors corrected before it stay counted.
- R8: `done` is a one-cycle pulse. It rises N cycles after the clock edge that samples `start`, where each clean or uncorrectable sector adds 1 cycle and each corrected sector adds 3.
- R9: A repair reads the byte in one cycle. In the next cycle it writes back, at the same address, the returned byte XOR a one-hot mask.
- R10: Reset and every accepted `start` clear `err`, `corr_cnt`, `last_off` and `last_bit`. After each repair, `last_off` and `last_bit` hold that repair's offset and bit.
- R11: A `start` that arrives while `busy` is high is ignored. The codes are captured when a start is accepted, so later changes on the code inputs do not affect the running page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a page when idle |
| page_mode | input | 1 | 0: one sector, 1: four sectors |
| stored_ecc | input | 96 | Codes read from flash, 24 bits per sector |
| calc_ecc | input | 96 | Codes computed on read, 24 bits per sector |
| busy | output | 1 | Page in progress |
| done | output | 1 | One-cycle end-of-page pulse |
| err | output | 1 | Page ended on an uncorrectable sector |
| corr_cnt | output | 3 | Number of corrected sectors |
| last_off | output | 9 | Byte offset of the latest repair |
| last_bit | output | 3 | Bit index of the latest repair |
| buf_addr | output | 11 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe (data valid next cycle) |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte to write |
| buf_rdata | input | 8 | Buffer read data |

## Verification
The result of a page is due a fixed number of cycles after the start edge. A skipped, clean or aborting sector takes one cycle and a repaired sector takes three, so the bench adds these costs from its own model of each sector. It counts cycles on falling edges from the start edge until `done` appears and compares the count with that sum. `err`, `corr_cnt`, the last repair position and the full buffer contents are read at that same falling edge, when all of them have settled. The read-then-write pairing and the single-cycle `done` are checked on every cycle by the bound properties.

// File: rtl/secc_pkg.sv
package secc_pkg;

   // outcome of one sector
   typedef enum logic [1:0] {
      V_CLEAN = 2'd0,
      V_FIX   = 2'd1,
      V_FAIL  = 2'd2
   } verdict_t;

   // sequencer states
   typedef enum logic [1:0] {
      S_IDLE = 2'd0,
      S_EVAL = 2'd1,
      S_RD   = 2'd2,
      S_WR   = 2'd3
   } seq_t;

endpackage

// File: rtl/secc_syn_map.sv
// Gathers the syndrome from the byte-wise XOR of the two codes.
module secc_syn_map #(
   parameter int ECC_BYTES = 3,
   localparam int SYN_W = ECC_BYTES * 8
) (
   input  logic [SYN_W-1:0] stored,
   input  logic [SYN_W-1:0] calc,
   output logic [SYN_W-1:0] syn,
   output logic             identical,
   output logic             erased
);
   logic [SYN_W-1:0] diff;

   assign diff      = stored ^ calc;
   assign identical = (diff == '0);
   assign erased    = (stored == '1) && (calc == '0);

   // byte 2 carries the column pairs in its upper six bits and the
   // top row pair in its lower two bits
   assign syn = {diff[17:16], diff[15:8], diff[7:0], diff[23:18]};
endmodule

// File: rtl/secc_popcount.sv
// Ones count of the syndrome: one count per byte, then a sum.
module secc_popcount #(
   parameter int SYN_W = 24,
   localparam int NB   = SYN_W / 8,
   localparam int PC_W = $clog2(SYN_W + 1)
) (
   input  logic [SYN_W-1:0] vec,
   output logic [PC_W-1:0]  count
);
   logic [3:0] part [NB];

   for (genvar g = 0; g < NB; g++) begin : g_byte
      always_comb begin
         part[g] = '0;
         for (int b = 0; b < 8; b++)
            part[g] = part[g] + 4'(vec[g*8+b]);
      end
   end

   always_comb begin
      count = '0;
      for (int g = 0; g < NB; g++)
         count = count + PC_W'(part[g]);
   end
endmodule

// File: rtl/secc_classify.sv
// Sorts a syndrome into clean / single-bit fix / uncorrectable.
module secc_classify import secc_pkg::*; #(
   parameter int SYN_W = 24,
   localparam int OFF_W = SYN_W / 2 - 3,
   localparam int PC_W  = $clog2(SYN_W + 1),
   localparam int FIX_PC = SYN_W / 2
) (
   input  logic [SYN_W-1:0] syn,
   input  logic             identical,
   input  logic             erased,
   output verdict_t         verdict,
   output logic [OFF_W-1:0] off,
   output logic [2:0]       bit_idx
);
   logic [PC_W-1:0] ones;

   secc_popcount #(.SYN_W(SYN_W)) u_pc (
      .vec   (syn),
      .count (ones)
   );

   // odd syndrome bits carry the position
   for (genvar i = 0; i < 3; i++) begin : g_bit
      assign bit_idx[i] = syn[2*i+1];
   end
   for (genvar i = 0; i < OFF_W; i++) begin : g_off
      assign off[i] = syn[2*i+7];
   end

   always_comb begin
      if (identical)
         verdict = V_CLEAN;
      else if (ones == PC_W'(FIX_PC))
         verdict = V_FIX;
      else if (ones == '0)
         verdict = V_CLEAN;
      else if (ones == PC_W'(1) || ones == PC_W'(FIX_PC - 1))
         verdict = V_FAIL;
      else if (erased)
         verdict = V_CLEAN;
      else
         verdict = V_FAIL;
   end
endmodule

// File: rtl/secc_corrector.sv
// Page-level sequencer: walks the sectors, repairs single-bit errors
// through a read-modify-write on the sector buffer.
module secc_corrector import secc_pkg::*; #(
   parameter int SECT_BYTES = 512,
   parameter int ECC_BYTES  = 3,
   parameter int MAX_SECT   = 4,
   localparam int SYN_W  = ECC_BYTES * 8,
   localparam int OFF_W  = $clog2(SECT_BYTES),
   localparam int SECT_W = $clog2(MAX_SECT),
   localparam int ADDR_W = SECT_W + OFF_W,
   localparam int CNT_W  = $clog2(MAX_SECT + 1),
   localparam int BUS_W  = MAX_SECT * SYN_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              page_mode,
   input  logic [BUS_W-1:0]  stored_ecc,
   input  logic [BUS_W-1:0]  calc_ecc,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [CNT_W-1:0]  corr_cnt,
   output logic [OFF_W-1:0]  last_off,
   output logic [2:0]        last_bit,
   output logic [ADDR_W-1:0] buf_addr,
   output logic              buf_rd_en,
   output logic              buf_wr_en,
   output logic [7:0]        buf_wdata,
   input  logic [7:0]        buf_rdata
);
   // elaboration-time parameter checks
   if (ECC_BYTES != 3) begin : g_bad_ecc
      $error("secc_corrector: syndrome layout needs three code bytes");
   end
   if (SYN_W / 2 - 3 != OFF_W) begin : g_bad_sect
      $error("secc_corrector: sector size does not match code width");
   end
   if (MAX_SECT < 2 || (1 << SECT_W) != MAX_SECT) begin : g_bad_cnt
      $error("secc_corrector: MAX_SECT must be a power of two >= 2");
   end

   seq_t              state_q;
   logic [BUS_W-1:0]  st_q, ca_q;
   logic [SECT_W-1:0] idx_q, last_idx_q;
   logic [OFF_W-1:0]  fix_off_q;
   logic [2:0]        fix_bit_q;
   logic              done_q, err_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [OFF_W-1:0]  lo_q;
   logic [2:0]        lb_q;

   logic [SYN_W-1:0]  sel_st, sel_ca, syn;
   logic              same, blank;
   verdict_t          verdict;
   logic [OFF_W-1:0]  dec_off;
   logic [2:0]        dec_bit;
   logic              at_last;

   assign sel_st  = st_q[32'(idx_q)*SYN_W +: SYN_W];
   assign sel_ca  = ca_q[32'(idx_q)*SYN_W +: SYN_W];
   assign at_last = (idx_q == last_idx_q);

   secc_syn_map #(.ECC_BYTES(ECC_BYTES)) u_map (
      .stored    (sel_st),
      .calc      (sel_ca),
      .syn       (syn),
      .identical (same),
      .erased    (blank)
   );

   secc_classify #(.SYN_W(SYN_W)) u_cls (
      .syn       (syn),
      .identical (same),
      .erased    (blank),
      .verdict   (verdict),
      .off       (dec_off),
      .bit_idx   (dec_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= S_IDLE;
         st_q       <= '0;
         ca_q       <= '0;
         idx_q      <= '0;
         last_idx_q <= '0;
         fix_off_q  <= '0;
         fix_bit_q  <= '0;
         done_q     <= 1'b0;
         err_q      <= 1'b0;
         cnt_q      <= '0;
         lo_q       <= '0;
         lb_q       <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            S_IDLE: begin
               if (start) begin
                  st_q       <= stored_ecc;
                  ca_q       <= calc_ecc;
                  idx_q      <= '0;
                  last_idx_q <= page_mode ? SECT_W'(MAX_SECT - 1) : '0;
                  err_q      <= 1'b0;
                  cnt_q      <= '0;
                  lo_q       <= '0;
                  lb_q       <= '0;
                  state_q    <= S_EVAL;
               end
            end
            S_EVAL: begin
               unique case (verdict)
                  V_FAIL: begin
                     err_q   <= 1'b1;
                     done_q  <= 1'b1;
                     state_q <= S_IDLE;
                  end
                  V_FIX: begin
                     fix_off_q <= dec_off;
                     fix_bit_q <= dec_bit;
                     state_q   <= S_RD;
                  end
                  default: begin
                     if (at_last) begin
                        done_q  <= 1'b1;
                        state_q <= S_IDLE;
                     end else begin
                        idx_q <= idx_q + SECT_W'(1);
                     end
                  end
               endcase
            end
            S_RD: state_q <= S_WR;
            S_WR: begin
               cnt_q <= cnt_q + CNT_W'(1);
               lo_q  <= fix_off_q;
               lb_q  <= fix_bit_q;
               if (at_last) begin
                  done_q  <= 1'b1;
                  state_q <= S_IDLE;
               end else begin
                  idx_q   <= idx_q + SECT_W'(1);
                  state_q <= S_EVAL;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign busy      = (state_q != S_IDLE);
   assign done      = done_q;
   assign err       = err_q;
   assign corr_cnt  = cnt_q;
   assign last_off  = lo_q;
   assign last_bit  = lb_q;
   assign buf_addr  = {idx_q, fix_off_q};
   assign buf_rd_en = (state_q == S_RD);
   assign buf_wr_en = (state_q == S_WR);
   assign buf_wdata = buf_rdata ^ (8'(1) << fix_bit_q);
endmodule

// File: rtl/secc_corrector_chk.sv
module secc_corrector_chk #(
   parameter int SECT_BYTES = 512,
   parameter int MAX_SECT   = 4,
   localparam int OFF_W  = $clog2(SECT_BYTES),
   localparam int SECT_W = $clog2(MAX_SECT),
   localparam int ADDR_W = SECT_W + OFF_W,
   localparam int CNT_W  = $clog2(MAX_SECT + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [CNT_W-1:0]  corr_cnt,
   input logic [ADDR_W-1:0] buf_addr,
   input logic              buf_rd_en,
   input logic              buf_wr_en
);
   // R9
   rmw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rd_en |=> buf_wr_en && (buf_addr == $past(buf_addr)));

   // R9
   no_stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> $past(buf_rd_en));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R7
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |=> corr_cnt == $past(corr_cnt) + CNT_W'(1));

   // R7
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(corr_cnt) <= MAX_SECT);

   // R10
   clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy && corr_cnt == '0 && !err);

   // R2
   quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !buf_rd_en && !buf_wr_en);
endmodule

bind secc_corrector secc_corrector_chk #(
   .SECT_BYTES (SECT_BYTES),
   .MAX_SECT   (MAX_SECT)
) u_chk (.*);

// File: tb/sim_secc_corrector.sv
`timescale 1ns/1ps
module sim_secc_corrector;
   localparam int NS = 4;
   localparam int SW = 24;
   localparam int MB = 2048;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, page_mode = 1'b0;
   logic [NS*SW-1:0] stored_ecc = '0, calc_ecc = '0;
   logic busy, done, err, buf_rd_en, buf_wr_en;
   logic [2:0] corr_cnt, last_bit;
   logic [8:0] last_off;
   logic [10:0] buf_addr;
   logic [7:0] buf_wdata, rdata_q;

   int n_chk = 0, n_bad = 0;
   logic [7:0] mem [0:MB-1];
   logic [7:0] exp_mem [0:MB-1];
   logic [23:0] pst [NS];
   logic [23:0] pca [NS];

   always #2 clk = ~clk;

   function automatic logic [7:0] init_byte(input int a);
      return 8'((a * 37) ^ (a >> 3) ^ 8'h5a);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < MB; a++) mem[a] <= init_byte(a);
      end else if (buf_wr_en) mem[buf_addr] <= buf_wdata;
      if (buf_rd_en) rdata_q <= mem[buf_addr];
   end

   secc_corrector u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .page_mode(page_mode),
      .stored_ecc(stored_ecc), .calc_ecc(calc_ecc), .busy(busy), .done(done),
      .err(err), .corr_cnt(corr_cnt), .last_off(last_off), .last_bit(last_bit),
      .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
      .buf_wdata(buf_wdata), .buf_rdata(rdata_q)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // syndrome from code difference (R1 layout)
   function automatic logic [23:0] scr(input logic [23:0] x);
      return {x[17:16], x[15:8], x[7:0], x[23:18]};
   endfunction
   // code difference that yields a given syndrome
   function automatic logic [23:0] unscr(input logic [23:0] s);
      return {s[5:0], s[23:22], s[21:14], s[13:6]};
   endfunction
   function automatic logic [23:0] fixsyn(input int off, input int bt);
      logic [23:0] s = '0;
      for (int i = 0; i < 12; i++) begin
         logic v = (i < 3) ? bt[i] : off[i-3];
         s[2*i+1] = v;
         s[2*i]   = ~v;
      end
      return s;
   endfunction
   function automatic logic [23:0] randsyn(input int k);
      logic [23:0] r = '0;
      while ($countones(r) < k) r[$urandom % 24] = 1'b1;
      return r;
   endfunction

   // kind: 0 identical, 1 fix, 2 given ones count, 3 erased, 4 erased-stored mismatch
   task automatic mk(input int s, input int kind, input int off, input int bt, input int pc);
      logic [23:0] st = 24'($urandom);
      case (kind)
         0: begin pst[s] = st; pca[s] = st; end
         1: begin pst[s] = st; pca[s] = st ^ unscr(fixsyn(off, bt)); end
         2: begin pst[s] = st; pca[s] = st ^ unscr(randsyn(pc)); end
         3: begin pst[s] = 24'hffffff; pca[s] = 24'h0; end
         default: begin pst[s] = 24'hffffff; pca[s] = ~unscr(randsyn(pc)); end
      endcase
   endtask

   task automatic run_page(input bit mode, input bit restart, input string tag);
      int n = mode ? NS : 1;
      int cost = 0, ecnt = 0, elo = 0, elb = 0, lat = 0, bad = 0;
      bit eerr = 0;
      for (int s = 0; s < n; s++) begin
         logic [23:0] sy = scr(pst[s] ^ pca[s]);
         int pc = $countones(sy);
         if (pc == 0) cost += 1;
         else if (pc == 12) begin
            int off = 0, bt = 0;
            for (int i = 0; i < 9; i++) off[i] = sy[2*i+7];
            for (int i = 0; i < 3; i++) bt[i] = sy[2*i+1];
            exp_mem[s*512+off] ^= 8'(1 << bt);
            ecnt++; elo = off; elb = bt; cost += 3;
         end else if (pc != 1 && pc != 11 && pst[s] == 24'hffffff && pca[s] == 24'h0)
            cost += 1;
         else begin
            cost += 1; eerr = 1; break;
         end
      end
      @(negedge clk);
      for (int s = 0; s < NS; s++) begin
         stored_ecc[s*SW +: SW] = pst[s];
         calc_ecc[s*SW +: SW]   = pca[s];
      end
      page_mode = mode;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && lat < 60) begin
         @(negedge clk);
         lat++;
         // R11: second start while busy with altered codes
         if (restart && lat == 1 && !done) begin
            start = 1'b1;
            stored_ecc = ~stored_ecc;
         end else start = 1'b0;
      end
      start = 1'b0;
      check(lat == cost, "R8", {tag, " latency"}, lat, cost);
      check(err == eerr, "R7", {tag, " err"}, int'(err), int'(eerr));
      check(int'(corr_cnt) == ecnt, "R7", {tag, " count"}, int'(corr_cnt), ecnt);
      check(int'(last_off) == elo && int'(last_bit) == elb, "R10",
            {tag, " last position"}, int'({last_off, last_bit}), (elo << 3) | elb);
      for (int a = 0; a < MB; a++) if (mem[a] !== exp_mem[a]) bad++;
      check(bad == 0, "R4", {tag, " buffer bytes differing"}, bad, 0);
      @(negedge clk);
      check(!done && !busy, "R8", {tag, " done pulse width"}, int'(done), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7741));
      for (int a = 0; a < MB; a++) exp_mem[a] = init_byte(a);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      check(!busy && !done && !err && corr_cnt == 0, "R10", "reset flags", int'(corr_cnt), 0);
      check(last_off == 0 && last_bit == 0 && !buf_rd_en && !buf_wr_en, "R10",
            "reset position", int'(last_off), 0);

      for (int s = 0; s < NS; s++) mk(s, 0, 0, 0, 0);
      run_page(0, 0, "R1 R2 identical");
      mk(0, 1, 0, 0, 0);
      run_page(0, 0, "R4 fix off0 bit0");
      mk(0, 0, 0, 0, 0); mk(1, 0, 0, 0, 0); mk(2, 0, 0, 0, 0); mk(3, 1, 511, 7, 0);
      run_page(1, 0, "R6 fix sector3 off511 bit7");
      mk(0, 2, 0, 0, 1);
      run_page(0, 0, "R3 one bit");
      mk(0, 2, 0, 0, 11);
      run_page(0, 0, "R3 eleven bits");
      mk(0, 3, 0, 0, 0);
      run_page(0, 0, "R5 erased");
      mk(0, 4, 0, 0, 5);
      run_page(0, 0, "R5 erased stored, nonzero computed");
      mk(0, 2, 0, 0, 7);
      run_page(0, 0, "R5 seven bits");
      mk(0, 1, 100, 3, 0); mk(1, 1, 200, 5, 0); mk(2, 2, 0, 0, 1); mk(3, 1, 300, 2, 0);
      run_page(1, 0, "R7 abort at sector2");
      mk(0, 0, 0, 0, 0); mk(1, 1, 17, 6, 0); mk(2, 1, 17, 6, 0); mk(3, 1, 17, 6, 0);
      run_page(0, 0, "R6 single sector ignores others");
      for (int s = 0; s < NS; s++) mk(s, 1, 40 + s, s, 0);
      run_page(1, 1, "R11 restart while busy");

      for (int p = 0; p < 60; p++) begin
         for (int s = 0; s < NS; s++) begin
            int r = $urandom % 10;
            int k = 2 + $urandom % 23;
            if (k == 11 || k == 12) k = 13;
            if (r < 3) mk(s, 0, 0, 0, 0);
            else if (r < 7) mk(s, 1, $urandom % 512, $urandom % 8, 0);
            else if (r == 7) mk(s, 3, 0, 0, 0);
            else if (r == 8) mk(s, 2, 0, 0, ($urandom % 2) ? 1 : 11);
            else mk(s, 2, 0, 0, k);
         end
         run_page(1'($urandom % 2), 0, "R1 R3 R4 R5 R6 random page");
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule